// File: doc/BRIEF.md
# Register-Write Command Decoder

This block sits at the receiving end of a byte stream of display-controller commands. It recognises register-write commands and applies them to a small internal register file. The file holds the video-timing, colour-depth, framebuffer-base and sync-control settings, and the block drives their committed values to the video pipeline. Every command starts with a marker byte. A register write consists of the marker, a write opcode, an address byte and a data byte. Any other opcode is treated as the header of a command class that this block does not handle: the block drops it and goes back to waiting for a marker.

A lock register lets software group a whole mode change into one atomic update. While the block is locked, writes collect in a shadow copy and the outputs do not move. Unlocking copies the entire shadow into the active registers in one clock and raises a one-cycle commit pulse. When the block is unlocked, each write takes effect on its own and pulses commit.

A power-down written to the sync register latches. Sync output then stays off until a complete mode sequence has been written inside a locked group and unlocked.

Top module: `regcmd_decoder`

## Requirements
- R1: A register write is the four accepted bytes 0xAF, 0x20, address, data. When the decoder is waiting for a command start, any accepted byte other than 0xAF is dropped and changes no output.
- R2: If the byte after 0xAF is not 0x20, both bytes are dropped with no register change, and the next byte is again treated as a possible command start.
- R3: While unlocked, a write to a stored address updates the matching output on the clock edge that accepts the data byte. `commit` is high for exactly the following cycle.
- R4: Writing 0x00 to address 0xFF locks the decoder. While it is locked, writes change no output and raise no commit.
- R5: Writing 0xFF to address 0xFF while locked copies every shadowed register to the outputs at once and pulses `commit` for one cycle. Writing 0xFF there while unlocked has no effect and raises no commit. Any other data value written to address 0xFF is ignored.
- R6: Byte order is fixed as follows. `base16` is {reg 0x20, reg 0x21, reg 0x22} and `base8` is {reg 0x26, reg 0x27, reg 0x28}, first address most significant. Timing word k (bits 16k+15:16k of `tmg_words`) is {reg 0x01+2k, reg 0x02+2k}, high byte at the lower address, for k = 0..11. `pix_clk` is {reg 0x1C, reg 0x1B}, so its low byte is at 0x1B.
- R7: `depth_24` equals bit 0 of register 0x00, where 0 means 16 bpp and 1 means 24 bpp.
- R8: `sync_mode` reports the committed value of register 0x1F: 0x00 means syncs on, 0x01 means blanked but powered, and 0x07 means powered down. `sync_on` is high only when `sync_mode` is 0x00.
- R9: Once 0x07 reaches register 0x1F, either by a direct write or through a commit, `sync_mode` reads 0x07 until an unlock commits a locked group that wrote every one of addresses 0x01–0x18, 0x1B and 0x1C and that leaves register 0x1F at a value other than 0x07.
- R10: After reset all registers read zero except register 0x1F, which reads 0x07. The decoder is unlocked and in power-down, and `commit` is low.
- R11: Writes to addresses 0x30–0xFE change no output and raise no commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Command byte present |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Always high; one byte accepted per cycle |
| commit | output | 1 | One-cycle pulse when new values reach the outputs |
| depth_24 | output | 1 | Colour depth select, 1 = 24 bpp |
| base16 | output | 24 | Base address of the 16 bpp plane |
| base8 | output | 24 | Base address of the 8 bpp plane |
| pix_clk | output | 16 | Pixel-clock setting |
| tmg_words | output | 192 | Twelve 16-bit timing words |
| sync_mode | output | 8 | Effective sync control value |
| sync_on | output | 1 | Horizontal and vertical sync enabled |

## Verification
The hardest state to reach is leaving power-down. Only a locked group that covers all 26 mode addresses and ends with a non-power-down sync value can clear it. The stimulus therefore runs three kinds of group: one that is incomplete, one full sequence that ends in 0x00, and one full sequence that ends in 0x07. A direct unlocked sync write is also tried while powered down. Each of these is checked to confirm that only the full sequence ending in 0x00 brings `sync_mode` back. A second effort goes to showing that malformed framing really resynchronises: after stray bytes and bad opcodes, a real write must land on the next marker.

// File: rtl/regcmd_pkg.sv
// Shared constants and types for the register-write command decoder.
// Assumes byte-wide commands and an 8-bit register address space.
package regcmd_pkg;
    localparam logic [7:0] CMD_MARK    = 8'hAF;
    localparam logic [7:0] OP_REGWR    = 8'h20;
    localparam logic [7:0] GATE_ADDR   = 8'hFF;
    localparam logic [7:0] GATE_CLOSE  = 8'h00;
    localparam logic [7:0] GATE_OPEN   = 8'hFF;
    localparam int         SYNC_IDX    = 31;
    localparam logic [7:0] SYNC_PWRDN  = 8'h07;

    typedef enum logic [1:0] {P_IDLE, P_OPC, P_ADDR, P_DATA} pstate_t;

    // Addresses that a locked group must cover to leave power-down.
    function automatic logic mode_reg_needed(input int a);
        return (a >= 1 && a <= 24) || a == 27 || a == 28;
    endfunction
endpackage

// File: rtl/regcmd_parser.sv
// Byte-stream framer: finds marker/opcode/address/data and emits one
// write strobe per well-formed register write. Assumes a byte is taken
// on every cycle that in_valid is high.
module regcmd_parser
    import regcmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       wr_stb,
    output logic [7:0] wr_addr,
    output logic [7:0] wr_data
);
    pstate_t    st_q;
    logic [7:0] addr_q;

    // Advance the framing state on each accepted byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= P_IDLE;
            addr_q <= '0;
        end else if (in_valid) begin
            case (st_q)
                P_IDLE: if (in_data == CMD_MARK) st_q <= P_OPC;
                P_OPC:  st_q <= (in_data == OP_REGWR) ? P_ADDR : P_IDLE;
                P_ADDR: begin
                    addr_q <= in_data;
                    st_q   <= P_DATA;
                end
                default: st_q <= P_IDLE;
            endcase
        end
    end

    // The data byte itself is the write payload.
    assign wr_stb  = in_valid && (st_q == P_DATA);
    assign wr_addr = addr_q;
    assign wr_data = in_data;
endmodule

// File: rtl/regcmd_bank.sv
// Active and shadow register copies with lock gating, group commit and
// the power-down latch. Assumes NREG covers the sync register index.
module regcmd_bank
    import regcmd_pkg::*;
#(
    parameter int NREG = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    output logic [NREG*8-1:0] act_flat,
    output logic              commit,
    output logic              locked,
    output logic              pd
);
    localparam int         AW     = $clog2(NREG);
    localparam logic [7:0] NREG_B = 8'(NREG);

    logic [7:0]      act_q [NREG];
    logic [7:0]      shd_q [NREG];
    logic [NREG-1:0] seen_q;
    logic [NREG-1:0] need;
    logic            group_full;
    logic            in_range;

    // Constant mask of addresses a full mode sequence must write.
    for (genvar i = 0; i < NREG; i++) begin : g_need
        assign need[i] = mode_reg_needed(i);
        assign act_flat[i*8 +: 8] = act_q[i];
    end

    assign group_full = &(seen_q | ~need);
    assign in_range   = wr_addr < NREG_B;

    // Apply writes, lock transitions and group commits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                act_q[i] <= '0;
                shd_q[i] <= '0;
            end
            act_q[SYNC_IDX] <= SYNC_PWRDN;
            shd_q[SYNC_IDX] <= SYNC_PWRDN;
            seen_q <= '0;
            locked <= 1'b0;
            pd     <= 1'b1;
            commit <= 1'b0;
        end else begin
            commit <= 1'b0;
            if (wr_stb && wr_addr == GATE_ADDR) begin
                if (wr_data == GATE_CLOSE) begin
                    locked <= 1'b1;
                    seen_q <= '0;
                end else if (wr_data == GATE_OPEN && locked) begin
                    locked <= 1'b0;
                    commit <= 1'b1;
                    for (int i = 0; i < NREG; i++) act_q[i] <= shd_q[i];
                    if (shd_q[SYNC_IDX] == SYNC_PWRDN) pd <= 1'b1;
                    else if (group_full)               pd <= 1'b0;
                end
            end else if (wr_stb && in_range) begin
                shd_q[wr_addr[AW-1:0]] <= wr_data;
                if (locked) begin
                    seen_q[wr_addr[AW-1:0]] <= 1'b1;
                end else begin
                    act_q[wr_addr[AW-1:0]] <= wr_data;
                    commit <= 1'b1;
                    if (int'(wr_addr) == SYNC_IDX && wr_data == SYNC_PWRDN) pd <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/regcmd_decoder.sv
// Top of the register-write command decoder: framer plus register bank,
// with committed registers mapped onto named output fields.
// Assumes NREG > 0x28 so every mapped address is stored.
module regcmd_decoder
    import regcmd_pkg::*;
#(
    parameter int NREG = 48,
    parameter int NTMG = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    output logic               in_ready,
    output logic               commit,
    output logic               depth_24,
    output logic [23:0]        base16,
    output logic [23:0]        base8,
    output logic [15:0]        pix_clk,
    output logic [NTMG*16-1:0] tmg_words,
    output logic [7:0]         sync_mode,
    output logic               sync_on
);
    localparam int B16_A = 32;
    localparam int B8_A  = 38;
    localparam int PCK_A = 27;
    localparam int TMG_A = 1;

    logic              wr_stb;
    logic [7:0]        wr_addr;
    logic [7:0]        wr_data;
    logic [NREG*8-1:0] act_flat;
    logic              bank_locked;
    logic              bank_pd;
    logic              unused_regs;

    regcmd_parser u_parser (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_data (in_data),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    regcmd_bank #(.NREG(NREG)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_stb  (wr_stb),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .act_flat(act_flat),
        .commit  (commit),
        .locked  (bank_locked),
        .pd      (bank_pd)
    );

    // Timing words: high byte at the lower address of each pair.
    for (genvar k = 0; k < NTMG; k++) begin : g_tmg
        assign tmg_words[k*16 +: 16] = {act_flat[(TMG_A+2*k)*8 +: 8],
                                        act_flat[(TMG_A+2*k+1)*8 +: 8]};
    end

    // Field mapping of the committed registers.
    assign in_ready  = 1'b1;
    assign depth_24  = act_flat[0];
    assign base16    = {act_flat[B16_A*8 +: 8], act_flat[(B16_A+1)*8 +: 8],
                        act_flat[(B16_A+2)*8 +: 8]};
    assign base8     = {act_flat[B8_A*8 +: 8], act_flat[(B8_A+1)*8 +: 8],
                        act_flat[(B8_A+2)*8 +: 8]};
    assign pix_clk   = {act_flat[(PCK_A+1)*8 +: 8], act_flat[PCK_A*8 +: 8]};
    assign sync_mode = bank_pd ? SYNC_PWRDN : act_flat[SYNC_IDX*8 +: 8];
    assign sync_on   = (sync_mode == 8'h00);
    assign unused_regs = ^act_flat;
endmodule

// File: rtl/regcmd_decoder_chk.sv
// Protocol checker for regcmd_decoder, attached by bind.
module regcmd_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        commit,
    input logic        locked,
    input logic        pd,
    input logic [23:0] base16,
    input logic [23:0] base8,
    input logic [15:0] pix_clk,
    input logic [7:0]  sync_mode,
    input logic        sync_on
);
    // R3
    commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
    // R3
    commit_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(in_valid));
    // R4
    locked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> (!commit && $stable(base16) && $stable(base8)
                                       && $stable(pix_clk) && $stable(sync_mode)));
    // R5
    unlock_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> commit);
    // R9
    pd_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pd) |-> (commit && $past(locked)));
    // R8
    sync_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_on |-> !pd);
endmodule

bind regcmd_decoder regcmd_decoder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .commit   (commit),
    .locked   (bank_locked),
    .pd       (bank_pd),
    .base16   (base16),
    .base8    (base8),
    .pix_clk  (pix_clk),
    .sync_mode(sync_mode),
    .sync_on  (sync_on)
);

// File: tb/test_regcmd_decoder.sv
module test_regcmd_decoder;
    typedef struct packed {
        logic         commit;
        logic         depth;
        logic [23:0]  b16;
        logic [23:0]  b8;
        logic [15:0]  pix;
        logic [7:0]   sm;
        logic         son;
        logic [191:0] tmg;
    } snap_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [7:0]   in_data = '0;
    logic         in_ready, commit, depth_24, sync_on;
    logic [23:0]  base16, base8;
    logic [15:0]  pix_clk;
    logic [191:0] tmg_words;
    logic [7:0]   sync_mode;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    snap_t exp_q[$];
    string tag_q[$];

    logic [7:0] m_act [48];
    logic [7:0] m_shd [48];
    bit         m_lock, m_pd, exp_commit;
    bit [47:0]  m_seen;

    always #2 clk = ~clk;

    regcmd_decoder i_regcmd_decoder (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .commit(commit), .depth_24(depth_24),
        .base16(base16), .base8(base8), .pix_clk(pix_clk),
        .tmg_words(tmg_words), .sync_mode(sync_mode), .sync_on(sync_on)
    );

    // Expected outputs derived from the reference register state.
    function automatic snap_t m_snap(bit c);
        snap_t s;
        s.commit = c;
        s.depth  = m_act[0][0];
        s.b16    = {m_act[32], m_act[33], m_act[34]};
        s.b8     = {m_act[38], m_act[39], m_act[40]};
        s.pix    = {m_act[28], m_act[27]};
        s.sm     = m_pd ? 8'h07 : m_act[31];
        s.son    = (s.sm == 8'h00);
        for (int k = 0; k < 12; k++) s.tmg[k*16 +: 16] = {m_act[1+2*k], m_act[2+2*k]};
        return s;
    endfunction

    // Reference effect of one register write, per the requirements.
    task automatic m_write(input logic [7:0] a, input logic [7:0] d, output bit c);
        bit full;
        c = 0;
        if (a == 8'hFF) begin
            if (d == 8'h00) begin
                m_lock = 1; m_seen = '0;
            end else if (d == 8'hFF && m_lock) begin
                full = 1;
                for (int i = 1; i <= 24; i++) full &= m_seen[i];
                full &= m_seen[27] & m_seen[28];
                m_lock = 0; c = 1;
                for (int i = 0; i < 48; i++) m_act[i] = m_shd[i];
                if (m_shd[31] == 8'h07) m_pd = 1;
                else if (full)          m_pd = 0;
            end
        end else if (a < 8'd48) begin
            m_shd[a] = d;
            if (m_lock) m_seen[a] = 1;
            else begin
                m_act[a] = d; c = 1;
                if (a == 8'd31 && d == 8'h07) m_pd = 1;
            end
        end
    endtask

    // Driver: present one byte and queue the expected result.
    task automatic send(input logic [7:0] b, input string tag);
        in_valid = 1'b1;
        in_data  = b;
        exp_q.push_back(m_snap(exp_commit));
        tag_q.push_back(tag);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
        bit c;
        exp_commit = 0;
        send(8'hAF, tag);
        send(8'h20, tag);
        send(a, tag);
        m_write(a, d, c);
        exp_commit = c;
        send(d, tag);
        exp_commit = 0;
    endtask

    // Locked group writing every mode address, ending with a sync value.
    task automatic mode_seq(input logic [7:0] sv, input string tag);
        wr(8'hFF, 8'h00, tag);
        for (int a = 1; a <= 24; a++) wr(8'(a), 8'(a * 5 + sv), tag);
        wr(8'h1B, 8'h21 ^ sv, tag);
        wr(8'h1C, 8'h43, tag);
        wr(8'h1F, sv, tag);
        wr(8'hFF, 8'hFF, tag);
    endtask

    // Monitor: compare outputs just after each edge against the queue.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            snap_t e, a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = {commit, depth_24, base16, base8, pix_clk, sync_mode, sync_on, tmg_words};
            n_chk++;
            if (a !== e || in_ready !== 1'b1) begin
                n_bad++;
                $display("FAIL %s: actual %h expected %h", t, a, e);
            end
        end
    end

    initial begin
        #400000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 48; i++) begin m_act[i] = '0; m_shd[i] = '0; end
        m_act[31] = 8'h07; m_shd[31] = 8'h07;
        m_lock = 0; m_pd = 1; m_seen = '0; exp_commit = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        exp_q.push_back(m_snap(0)); tag_q.push_back("R10 reset state");
        @(negedge clk);

        wr(8'h20, 8'h12, "R6 base16 msb first");
        wr(8'h21, 8'h34, "R6 base16 mid");
        wr(8'h22, 8'h56, "R3 unlocked write commits");
        wr(8'h26, 8'hAB, "R6 base8 msb first");
        wr(8'h27, 8'hCD, "R6 base8 mid");
        wr(8'h28, 8'hEF, "R6 base8 lsb");
        wr(8'h1B, 8'h34, "R6 pixel clock low byte");
        wr(8'h1C, 8'h12, "R6 pixel clock high byte");
        wr(8'h01, 8'h0A, "R6 timing word high");
        wr(8'h02, 8'h0B, "R6 timing word low");
        wr(8'h00, 8'h01, "R7 depth 24");
        wr(8'h00, 8'h00, "R7 depth 16");

        send(8'h20, "R1 stray byte dropped");
        send(8'h55, "R1 stray byte dropped");
        send(8'h00, "R1 stray byte dropped");
        wr(8'h21, 8'h99, "R1 resync after stray bytes");

        send(8'hAF, "R2 bad opcode");
        send(8'h30, "R2 bad opcode");
        send(8'h77, "R2 idle after bad opcode");
        send(8'hAF, "R2 marker as opcode");
        send(8'hAF, "R2 marker as opcode");
        send(8'h20, "R2 idle after marker opcode");
        wr(8'h22, 8'h44, "R2 parse resumes");

        wr(8'h1F, 8'h00, "R9 direct write keeps power-down");

        wr(8'hFF, 8'h00, "R4 lock");
        wr(8'h20, 8'h77, "R4 locked write hidden");
        wr(8'h00, 8'h01, "R4 locked depth hidden");
        wr(8'h1F, 8'h00, "R4 locked sync hidden");
        wr(8'hFF, 8'hFF, "R5 unlock commits group R9 partial group stays down");

        mode_seq(8'h00, "R9 full group releases power-down");
        wr(8'h1F, 8'h01, "R8 blank but powered");
        wr(8'h1F, 8'h00, "R8 syncs on");

        wr(8'hFF, 8'hFF, "R5 unlock while unlocked ignored");
        wr(8'hFF, 8'h55, "R5 other gate value ignored");
        wr(8'h20, 8'h11, "R5 still unlocked");
        wr(8'h30, 8'h5A, "R11 unmapped address");
        wr(8'h80, 8'h5A, "R11 unmapped address");

        wr(8'h1F, 8'h07, "R9 direct power-down");
        wr(8'h1F, 8'h00, "R9 stays powered down");
        mode_seq(8'h07, "R9 group ending in power-down");
        mode_seq(8'h01, "R9 group release to blank");

        repeat (3) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule